// File: doc/BRIEF.md
# Command and Data Timeout Monitor

This block watches one command sequence on a memory-card host interface and raises two kinds of timeout. The data timeout uses a free-running prescaler that divides the system clock by a fixed ratio. A saturating 16-bit counter counts the prescaler's pulses while a sequence is active and compares them against a programmable limit. A sequence end or an abort clears the counter and stops it. Once the limit is reached and the sequence is still active, every further prescaler pulse raises the flag-set condition again. Firmware is therefore expected to abort the sequence before clearing the sticky flag.

The command timeout counts transfer-clock ticks from the moment a command has been sent. It stops when the response has been received or when the sequence is aborted. A select bit chooses a limit of 128 or 256 ticks. The data-busy phase, card framing and CRC are handled elsewhere.

Top module: `xfer_timeout_mon`

## Requirements
- R1: After reset, `dto_flag`, `cto_flag` and `dto_over` are 0 and `dto_limit` reads 16'hFFFF.
- R2: The prescaler counts system clocks from reset release and emits one pulse every PRESCALE_DIV clocks (default 10000). The first pulse falls on the PRESCALE_DIV-th rising edge after reset release. A sequence start does not realign its phase.
- R3: The data count starts from zero when `seq_start` is sampled and advances by one on each later prescaler pulse. With `dto_irq_en` = 1, `dto_flag` rises on the edge of the pulse that brings the count to `dto_limit`, and not earlier.
- R4: With `dto_irq_en` = 0, `dto_flag` stays 0. `dto_over` still rises on that same edge, and it reports count >= limit while the sequence is active.
- R5: While the sequence stays active past the limit, each further prescaler pulse sets `dto_flag` again. This holds even after the flag has been cleared by a one-cycle `dto_flag_clr`.
- R6: `seq_end` or `seq_abort` clears the data count and halts it. After that, `dto_over` is 0, a cleared `dto_flag` stays 0, and a new sequence needs the full limit again.
- R7: If `dto_flag_clr` and a flag-set condition fall in the same cycle, `dto_flag` stays set. A `dto_flag_clr` alone clears the flag on the next edge.
- R8: The data count saturates at its maximum value and never wraps to zero without a clear.
- R9: With `cto_sel` = 0, `cto_flag` rises on the edge of the 128th `xfer_tick` after `cmd_sent`, and not on the 127th.
- R10: With `cto_sel` = 1, `cto_flag` rises on the edge of the 256th `xfer_tick` after `cmd_sent`, and not on the 255th.
- R11: `rsp_done` or `seq_abort` before the limit stops the command count, and later ticks raise no `cto_flag`.
- R12: The command counter sets `cto_flag` once and stops. The flag stays set through further ticks until the next `cmd_sent` clears it, one edge later.
- R13: A cycle with `lim_we` = 1 loads `lim_wdata` into `dto_limit`, and the new value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Command sequence begins |
| seq_end | input | 1 | Command sequence completed |
| seq_abort | input | 1 | Firmware abort of the sequence |
| cmd_sent | input | 1 | Command transmission finished |
| rsp_done | input | 1 | Response reception finished |
| xfer_tick | input | 1 | One transfer-clock period elapsed |
| cto_sel | input | 1 | Command limit: 0 = 128 ticks, 1 = 256 ticks |
| dto_irq_en | input | 1 | Enables setting of the data-timeout flag |
| lim_we | input | 1 | Write strobe for the data-timeout limit |
| lim_wdata | input | 16 | New data-timeout limit (prescaler pulses) |
| dto_flag_clr | input | 1 | Write-one-to-clear for `dto_flag` |
| dto_limit | output | 16 | Current data-timeout limit |
| dto_over | output | 1 | Data-timeout error state (count >= limit, sequence active) |
| dto_flag | output | 1 | Sticky data-timeout flag |
| cto_flag | output | 1 | Command-timeout flag |

## Verification
The hardest situation to reach is a flag clear that lands in the same cycle as a re-fired set condition. That cycle only exists at a prescaler pulse edge after the limit has already been passed. The bench keeps its own count of edges since reset release, which follows from R2. It starts each sequence just after a pulse edge, so every later pulse lands on a known edge. It can then place `dto_flag_clr` exactly on a pulse edge or just after one. The prescaler division is overridden to a small value so that several limits fit in the run.

// File: rtl/xtm_pkg.sv
package xtm_pkg;
  localparam int unsigned DTO_W = 16;
  localparam int unsigned CTO_SHORT_TICKS = 128;
  localparam int unsigned CTO_LONG_TICKS = 256;
endpackage

// File: rtl/xtm_prescaler.sv
module xtm_prescaler #(
  parameter int unsigned DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    pulse = (cnt_q == LAST);
    cnt_d = pulse ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);                                           // R2
  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && DIV > 1) |=> !pulse);                           // R2
endmodule

// File: rtl/xtm_dto_counter.sv
module xtm_dto_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic         pulse,
  input  logic [W-1:0] limit,
  output logic         hit,
  output logic         over
);
  localparam logic [W-1:0] CMAX = '1;

  logic         act_q, act_d;
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         adv;

  always_comb begin
    cnt_inc = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
    adv     = act_q && pulse && !stop;
    hit     = adv && (cnt_inc >= limit);
    over    = act_q && (cnt_q >= limit);
    if (stop)       act_d = 1'b0;
    else if (start) act_d = 1'b1;
    else            act_d = act_q;
    if (stop || start) cnt_d = '0;
    else if (adv)      cnt_d = cnt_inc;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  AST_DTO_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !stop && !start) |=> cnt_q == CMAX);    // R8
  AST_DTO_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (cnt_q == '0 && !act_q));                        // R6
  AST_DTO_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !start) |=> $stable(cnt_q));                   // R6
endmodule

// File: rtl/xtm_cto_counter.sv
module xtm_cto_counter #(
  parameter int unsigned SHORT_TICKS = 128,
  parameter int unsigned LONG_TICKS  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_sent,
  input  logic stop,
  input  logic tick,
  input  logic sel,
  output logic expire
);
  localparam int unsigned CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] LIM_S = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_TICKS);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = sel ? LIM_L : LIM_S;
    expire = 1'b0;
    run_d  = run_q;
    cnt_d  = cnt_q;
    if (cmd_sent) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_d >= lim) begin
        expire = 1'b1;
        run_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CTO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_L);                                          // R10
  AST_CTO_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run_q);                                       // R12
  AST_CTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sent |=> (cnt_q == '0 && run_q));                     // R12
endmodule

// File: rtl/xfer_timeout_mon.sv
module xfer_timeout_mon #(
  parameter int unsigned PRESCALE_DIV = 10000,
  parameter int unsigned DTO_W        = xtm_pkg::DTO_W,
  parameter int unsigned CTO_SHORT    = xtm_pkg::CTO_SHORT_TICKS,
  parameter int unsigned CTO_LONG     = xtm_pkg::CTO_LONG_TICKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_start,
  input  logic             seq_end,
  input  logic             seq_abort,
  input  logic             cmd_sent,
  input  logic             rsp_done,
  input  logic             xfer_tick,
  input  logic             cto_sel,
  input  logic             dto_irq_en,
  input  logic             lim_we,
  input  logic [DTO_W-1:0] lim_wdata,
  input  logic             dto_flag_clr,
  output logic [DTO_W-1:0] dto_limit,
  output logic             dto_over,
  output logic             dto_flag,
  output logic             cto_flag
);
  logic             pre_pulse, dto_hit, cto_expire, dto_set;
  logic [DTO_W-1:0] lim_q, lim_d;
  logic             dflag_q, dflag_d, cflag_q, cflag_d;

  xtm_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .pulse(pre_pulse)
  );

  xtm_dto_counter #(.W(DTO_W)) u_dto (
    .clk(clk), .rst_n(rst_n), .start(seq_start),
    .stop(seq_end || seq_abort), .pulse(pre_pulse), .limit(lim_q),
    .hit(dto_hit), .over(dto_over)
  );

  xtm_cto_counter #(.SHORT_TICKS(CTO_SHORT), .LONG_TICKS(CTO_LONG)) u_cto (
    .clk(clk), .rst_n(rst_n), .cmd_sent(cmd_sent),
    .stop(rsp_done || seq_abort), .tick(xfer_tick), .sel(cto_sel),
    .expire(cto_expire)
  );

  always_comb begin
    lim_d   = lim_we ? lim_wdata : lim_q;
    dto_set = dto_hit && dto_irq_en;
    if (dto_set)           dflag_d = 1'b1;
    else if (dto_flag_clr) dflag_d = 1'b0;
    else                   dflag_d = dflag_q;
    if (cto_expire)        cflag_d = 1'b1;
    else if (cmd_sent)     cflag_d = 1'b0;
    else                   cflag_d = cflag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= '1;
      dflag_q <= 1'b0;
      cflag_q <= 1'b0;
    end else begin
      lim_q   <= lim_d;
      dflag_q <= dflag_d;
      cflag_q <= cflag_d;
    end
  end

  assign dto_limit = lim_q;
  assign dto_flag  = dflag_q;
  assign cto_flag  = cflag_q;

  AST_DTO_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dto_hit && dto_irq_en) |=> dto_flag);                    // R7
  AST_DTO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dto_irq_en && !dto_flag) |=> !dto_flag);                // R4
  AST_DTO_HIT_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dto_hit |-> pre_pulse);                                   // R5
  AST_CTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cto_flag && !cmd_sent) |=> cto_flag);                    // R12
  AST_LIM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |=> dto_limit == $past(lim_wdata));                // R13
endmodule

// File: tb/xfer_timeout_mon_tb.sv
module xfer_timeout_mon_tb;
  localparam int DIV = 16;

  logic        clk, rst_n;
  logic        seq_start, seq_end, seq_abort, cmd_sent, rsp_done, xfer_tick;
  logic        cto_sel, dto_irq_en, lim_we, dto_flag_clr;
  logic [15:0] lim_wdata, dto_limit;
  logic        dto_over, dto_flag, cto_flag;

  int n_run = 0, n_fail = 0, ecnt = 0;
  bit done = 0;

  xfer_timeout_mon #(.PRESCALE_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_end(seq_end),
    .seq_abort(seq_abort), .cmd_sent(cmd_sent), .rsp_done(rsp_done),
    .xfer_tick(xfer_tick), .cto_sel(cto_sel), .dto_irq_en(dto_irq_en),
    .lim_we(lim_we), .lim_wdata(lim_wdata), .dto_flag_clr(dto_flag_clr),
    .dto_limit(dto_limit), .dto_over(dto_over), .dto_flag(dto_flag),
    .cto_flag(cto_flag)
  );

  initial clk = 0;
  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  // limit, irq enable, finish with seq_end (1) or seq_abort (0)
  typedef struct packed { logic [15:0] lim; logic en; logic use_end; } row_t;
  localparam row_t ROWS [4] = '{
    '{16'd1, 1'b1, 1'b0}, '{16'd3, 1'b1, 1'b1},
    '{16'd2, 1'b0, 1'b0}, '{16'd4, 1'b1, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic cto_case(logic sel, int lim, string tag);
    cto_sel = sel;
    cmd_sent = 1; step(1); cmd_sent = 0;
    chk({tag, " cleared by cmd_sent"}, cto_flag, 0);
    xfer_tick = 1; step(lim - 1);
    chk({tag, " no flag one tick early"}, cto_flag, 0);
    step(1);
    chk({tag, " flag at limit"}, cto_flag, 1);
    step(5); xfer_tick = 0;
    chk("R12 flag sticky through ticks", cto_flag, 1);
  endtask

  initial begin
    rst_n = 0; seq_start = 0; seq_end = 0; seq_abort = 0; cmd_sent = 0;
    rsp_done = 0; xfer_tick = 0; cto_sel = 0; dto_irq_en = 0; lim_we = 0;
    lim_wdata = 0; dto_flag_clr = 0;
    step(3);
    rst_n = 1;
    chk("R1 dto_flag", dto_flag, 0);
    chk("R1 cto_flag", cto_flag, 0);
    chk("R1 dto_over", dto_over, 0);
    chk("R1 limit", dto_limit, 16'hFFFF);

    foreach (ROWS[i]) begin
      lim_we = 1; lim_wdata = ROWS[i].lim; step(1); lim_we = 0;
      chk("R13 limit written", dto_limit, ROWS[i].lim);
      dto_irq_en = ROWS[i].en;
      while (ecnt % DIV != 0) step(1);           // R2: just after a pulse edge
      seq_start = 1; step(1); seq_start = 0;
      step(ROWS[i].lim * DIV - 2);
      chk("R3 no flag before limit", dto_flag, 0);
      chk("R4 not over before limit", dto_over, 0);
      step(1);
      chk("R3/R4 flag at limit", dto_flag, ROWS[i].en);
      chk("R4 over at limit", dto_over, 1);
      if (ROWS[i].en) begin
        dto_flag_clr = 1; step(1); dto_flag_clr = 0;
        chk("R7 clear alone", dto_flag, 0);
        step(DIV - 2);
        chk("R5 still clear before pulse", dto_flag, 0);
        step(1);
        chk("R5 re-fire on next pulse", dto_flag, 1);
        step(DIV - 1);
        dto_flag_clr = 1; step(1); dto_flag_clr = 0;
        chk("R7 set wins over clear", dto_flag, 1);
      end
      if (ROWS[i].use_end) seq_end = 1; else seq_abort = 1;
      dto_flag_clr = 1; step(1);
      seq_end = 0; seq_abort = 0; dto_flag_clr = 0;
      chk("R6 over cleared by stop", dto_over, 0);
      step(3 * DIV);
      chk("R6 no flag after stop", dto_flag, 0);
    end

    cto_case(0, 128, "R9");
    cto_case(1, 256, "R10");
    cmd_sent = 1; step(1); cmd_sent = 0;
    chk("R12 new cmd clears flag", cto_flag, 0);
    cto_sel = 0;
    xfer_tick = 1; step(100); xfer_tick = 0;
    rsp_done = 1; step(1); rsp_done = 0;
    xfer_tick = 1; step(200); xfer_tick = 0;
    chk("R11 rsp_done stops count", cto_flag, 0);
    cmd_sent = 1; step(1); cmd_sent = 0;
    xfer_tick = 1; step(50); xfer_tick = 0;
    seq_abort = 1; step(1); seq_abort = 0;
    xfer_tick = 1; step(200); xfer_tick = 0;
    chk("R11 abort stops count", cto_flag, 0);
    chk("R8 no data flag with idle sequence", dto_flag, 0);

    finish_run();
  end
endmodule